// File: doc/BRIEF.md
# Real-Time Clock Once-per-Second Update Engine

This block keeps the time of day and the calendar for a real-time clock. It counts enable pulses from a 32.768 kHz time base and, once per second, moves an internal working copy of seconds, minutes, hours, weekday, day of month, month and year forward by one second. It then copies the result into a host-visible buffer, unless the host has frozen that buffer. The fields are stored in the format the host picks. That format is either binary or packed BCD. Hours are held either as 0–23 or as 1–12 with a PM flag in bit 7.

During each update the engine applies an optional daylight-saving rule. The clock moves forward one hour on the first Sunday of April and back one hour on the last Sunday of October. It also compares the new time against three alarm bytes, and any of those bytes can be set to don't-care. A status line warns the host shortly before each update. A one-cycle pulse marks the end of each update, and a second pulse, in the same cycle, marks an alarm match.

The host loads fields and alarm bytes through a plain write strobe and reads the buffer through a combinational address/data port. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. The oscillator and the host bus are outside the block.

Top module: `rtc_update_engine`

## Requirements
- R1: Reset state:
  - `uip`, `upd_done` and `alarm_hit` are 0.
  - The buffer reads seconds, minutes, hours and year as 0x00, and weekday, day and month as 0x01.
  - The alarm bytes read 0x00.
- R2: Divider run and stop:
  - The second divider runs only while `osc_sel` is 3'b010 or 3'b011.
  - Any other value stops it, and no update occurs while it is stopped.
  - On entering run, the first update comes after TICKS_PER_SEC/2 ticks. Later updates come every TICKS_PER_SEC ticks.
- R3: `uip` timing:
  - `uip` rises UIP_LEAD ticks before an update.
  - `uip` falls in the same cycle that `upd_done` pulses.
  - `upd_done` is high for exactly one cycle, one clock after the last tick of the second.
- R4: Transfer inhibit:
  - While `xfer_inhibit` is 1, updates leave the buffer unchanged while the working copy keeps counting.
  - `uip` stays 0 during inhibit.
- R5: Data format and carries:
  - `fmt_binary`=1 selects binary fields and 0 selects packed BCD (tens in bits 7:4).
  - Seconds carry into minutes at 59, and minutes carry into hours at 59.
- R6: Hour format:
  - `fmt_24h`=1 selects hours 0–23.
  - `fmt_24h`=0 selects hours 1–12 in bits 6:0, with bit 7 = PM.
  - 11:59:59 AM becomes 12:00:00 PM, 12:59:59 PM becomes 1:00:00 PM, and 11:59:59 PM becomes 12:00:00 AM of the next day.
- R7: Day rollover (the weekday runs 1–7 with 1 = Sunday):
  - The weekday wraps from 7 to 1.
  - The day of month wraps after the month length. February has 29 days when year mod 4 = 0 and 28 otherwise; April, June, September and November have 30 days.
  - Month 12 wraps to 1 and increments the year. Year 99 wraps to 0.
- R8: Alarm:
  - An alarm byte with bits 7:6 = 2'b11 is don't-care.
  - `alarm_hit` pulses together with `upd_done` when every other alarm byte equals the new seconds, minutes and hours bytes.
- R9: Spring forward: with `dst_en`=1, on a Sunday in April with day of month ≤ 7, 01:59:59 becomes 03:00:00.
- R10: Fall back:
  - With `dst_en`=1, on a Sunday in October with day of month ≥ 25, the first pass from 01:59:59 goes to 01:00:00.
  - Later passes that day go on to 02:00:00.
  - A day rollover re-arms the rule.
- R11: Address map for writes:
  - Addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 7 seconds alarm, 8 minutes alarm and 9 hours alarm.
  - A time write updates both the working copy and the buffer, and takes priority over an update in the same cycle.
  - Reads of addresses 10–15 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable per time-base period |
| osc_sel | input | 3 | Oscillator/divider control pattern |
| fmt_binary | input | 1 | 1 = binary fields, 0 = BCD |
| fmt_24h | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| dst_en | input | 1 | Enables daylight-saving adjustments |
| xfer_inhibit | input | 1 | Freezes the host buffer |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| uip | output | 1 | Update coming soon / in progress |
| upd_done | output | 1 | One-cycle pulse at the end of each update |
| alarm_hit | output | 1 | One-cycle alarm pulse, coincident with `upd_done` |

## Verification
The bench aims at the carry chains that touch every field at once: 23:59:59 on the last day of December in year 99, February 28 in leap and common years, and the 12-hour noon and midnight crossings in both formats. A design with a wrong month length or leap rule would land on day 29, 31 or 1 on the wrong date. A design that mishandles the PM bit would report 0 or 13 instead of 12. The two daylight-saving Sundays are driven, including the second pass through 01:59:59 in October; a design without the once-only flag would loop back to 01:00:00 forever. Start-up latency, the length of the `uip` lead, buffer freezing under inhibit and don't-care alarm bytes are also checked; an off-by-one divider or a buffer copied under inhibit shows up directly at the read port.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NF = 7;
  localparam int IX_SEC  = 0;
  localparam int IX_MIN  = 1;
  localparam int IX_HOUR = 2;
  localparam int IX_DOW  = 3;
  localparam int IX_DOM  = 4;
  localparam int IX_MON  = 5;
  localparam int IX_YEAR = 6;

  typedef logic [NF-1:0][7:0] tbuf_t;

  localparam tbuf_t RESET_TIME = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  // stored byte -> binary value
  function automatic logic [6:0] dec(input logic [7:0] v, input logic bin);
    return bin ? v[6:0] : 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // binary value -> stored byte
  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    logic [6:0] t;
    logic [6:0] r;
    t = v / 7'd10;
    r = v - t * 7'd10;
    return bin ? {1'b0, v} : {t[3:0], r[3:0]};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m, input logic [6:0] y);
    case (m)
      7'd2:                      return (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [2:0] osc_sel,
  input  logic       xfer_inhibit,
  output logic       upd_stb,
  output logic       uip
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST   = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF   = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] UIP_AT = CW'(TICKS_PER_SEC - 1 - UIP_LEAD);

  logic [CW-1:0] cnt_q;
  logic          running;

  assign running = (osc_sel == 3'b010) || (osc_sel == 3'b011);
  assign upd_stb = running && tick_en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= HALF;
      uip   <= 1'b0;
    end else if (!running) begin
      cnt_q <= HALF;
      uip   <= 1'b0;
    end else begin
      if (tick_en) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (xfer_inhibit || upd_stb) uip <= 1'b0;
      else if (tick_en && cnt_q == UIP_AT) uip <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_calc.sv
module rtc_calc
  import rtc_pkg::*;
(
  input  tbuf_t cur,
  input  logic  bin,
  input  logic  h24,
  input  logic  dst_en,
  input  logic  fall_done,
  output tbuf_t nxt,
  output logic  fall_set,
  output logic  day_roll
);
  logic [6:0] s, m, h, w, d, mo, y, h12, lim;
  logic       pm;
  logic [7:0] hb;

  always_comb begin
    s   = dec(cur[IX_SEC], bin);
    m   = dec(cur[IX_MIN], bin);
    w   = dec(cur[IX_DOW], bin);
    d   = dec(cur[IX_DOM], bin);
    mo  = dec(cur[IX_MON], bin);
    y   = dec(cur[IX_YEAR], bin);
    h12 = dec({1'b0, cur[IX_HOUR][6:0]}, bin);
    pm  = cur[IX_HOUR][7];
    if (h24) h = dec(cur[IX_HOUR], bin);
    else     h = ((h12 == 7'd12) ? 7'd0 : h12) + (pm ? 7'd12 : 7'd0);
    lim      = month_len(mo, y);
    day_roll = 1'b0;
    fall_set = 1'b0;

    if (s >= 7'd59) begin
      s = 7'd0;
      if (m >= 7'd59) begin
        m = 7'd0;
        if (h >= 7'd23) begin
          h = 7'd0;
          day_roll = 1'b1;
        end else h = h + 7'd1;
      end else m = m + 7'd1;
    end else s = s + 7'd1;

    if (day_roll) begin
      w = (w >= 7'd7) ? 7'd1 : w + 7'd1;
      if (d >= lim) begin
        d = 7'd1;
        if (mo >= 7'd12) begin
          mo = 7'd1;
          y  = (y >= 7'd99) ? 7'd0 : y + 7'd1;
        end else mo = mo + 7'd1;
      end else d = d + 7'd1;
    end

    if (dst_en && s == 7'd0 && m == 7'd0 && h == 7'd2 && w == 7'd1) begin
      if (mo == 7'd4 && d <= 7'd7) h = 7'd3;
      else if (mo == 7'd10 && d >= 7'd25 && !fall_done) begin
        h = 7'd1;
        fall_set = 1'b1;
      end
    end

    nxt[IX_SEC]  = enc(s, bin);
    nxt[IX_MIN]  = enc(m, bin);
    nxt[IX_DOW]  = enc(w, bin);
    nxt[IX_DOM]  = enc(d, bin);
    nxt[IX_MON]  = enc(mo, bin);
    nxt[IX_YEAR] = enc(y, bin);
    if (h24) begin
      hb = enc(h, bin);
      nxt[IX_HOUR] = hb;
    end else begin
      pm  = (h >= 7'd12);
      h12 = pm ? h - 7'd12 : h;
      if (h12 == 7'd0) h12 = 7'd12;
      hb  = enc(h12, bin);
      nxt[IX_HOUR] = {pm, hb[6:0]};
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int NB = 3
) (
  input  logic [NB-1:0][7:0] now_b,
  input  logic [NB-1:0][7:0] alm_b,
  output logic               match
);
  logic [NB-1:0] ok;

  for (genvar i = 0; i < NB; i++) begin : g_cmp
    assign ok[i] = (alm_b[i][7:6] == 2'b11) || (alm_b[i] == now_b[i]);
  end

  assign match = &ok;
endmodule

// File: rtl/rtc_update_engine.sv
module rtc_update_engine
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [2:0] osc_sel,
  input  logic       fmt_binary,
  input  logic       fmt_24h,
  input  logic       dst_en,
  input  logic       xfer_inhibit,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       uip,
  output logic       upd_done,
  output logic       alarm_hit
);
  localparam int NA = 3;
  localparam logic [3:0] ALM_BASE = 4'(NF);
  localparam logic [3:0] ALM_END  = 4'(NF + NA);

  tbuf_t                work_q, shown_q, nxt;
  logic [NA-1:0][7:0]   alm_q;
  logic                 fell_q, fall_set, day_roll, upd_stb, match;
  logic [3:0]           wr_aoff, rd_aoff;

  rtc_divider #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_LEAD(UIP_LEAD)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .osc_sel(osc_sel),
    .xfer_inhibit(xfer_inhibit), .upd_stb(upd_stb), .uip(uip)
  );

  rtc_calc u_calc (
    .cur(work_q), .bin(fmt_binary), .h24(fmt_24h), .dst_en(dst_en),
    .fall_done(fell_q), .nxt(nxt), .fall_set(fall_set), .day_roll(day_roll)
  );

  rtc_alarm #(.NB(NA)) u_alm (
    .now_b({nxt[IX_HOUR], nxt[IX_MIN], nxt[IX_SEC]}),
    .alm_b(alm_q), .match(match)
  );

  assign wr_aoff = wr_addr - ALM_BASE;
  assign rd_aoff = rd_addr - ALM_BASE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q    <= RESET_TIME;
      shown_q   <= RESET_TIME;
      alm_q     <= '0;
      fell_q    <= 1'b0;
      upd_done  <= 1'b0;
      alarm_hit <= 1'b0;
    end else begin
      upd_done  <= upd_stb;
      alarm_hit <= upd_stb && match;
      if (upd_stb) begin
        work_q <= nxt;
        if (!xfer_inhibit) shown_q <= nxt;
        if (day_roll)      fell_q  <= 1'b0;
        else if (fall_set) fell_q  <= 1'b1;
      end
      if (wr_en) begin
        if (wr_addr < ALM_BASE) begin
          work_q[wr_addr[2:0]]  <= wr_data;
          shown_q[wr_addr[2:0]] <= wr_data;
        end else if (wr_addr < ALM_END) begin
          alm_q[wr_aoff[1:0]] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    if (rd_addr < ALM_BASE)     rd_data = shown_q[rd_addr[2:0]];
    else if (rd_addr < ALM_END) rd_data = alm_q[rd_aoff[1:0]];
    else                        rd_data = 8'h00;
  end
endmodule

// File: rtl/rtc_update_engine_chk.sv
module rtc_update_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] osc_sel,
  input logic       xfer_inhibit,
  input logic       wr_en,
  input logic [3:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       uip,
  input logic       upd_done,
  input logic       alarm_hit
);
  AST_DONE_DROPS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> !uip); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done); // R3

  AST_UIP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> ($past(osc_sel == 3'b010 || osc_sel == 3'b011) && !$past(xfer_inhibit))); // R3

  AST_INHIBIT_NO_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_inhibit |=> !uip); // R4

  AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_inhibit) && !$past(wr_en) && $stable(rd_addr)) |-> $stable(rd_data)); // R4

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(osc_sel == 3'b010 || osc_sel == 3'b011) |=> !upd_done); // R2

  AST_HIT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> upd_done); // R8
endmodule

bind rtc_update_engine rtc_update_engine_chk u_chk (.*);

// File: tb/rtc_update_engine_tb.sv
module rtc_update_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TPS  = 64;
  localparam int LEAD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic [2:0] osc_sel = 3'b000;
  logic fmt_binary = 1'b1, fmt_24h = 1'b1, dst_en = 1'b0, xfer_inhibit = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic uip, upd_done, alarm_hit;

  int checks = 0, errors = 0;
  bit finished = 0;
  int es, em, eh, ew, ed, emo, ey;
  bit efell = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_update_engine #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .osc_sel(osc_sel),
    .fmt_binary(fmt_binary), .fmt_24h(fmt_24h), .dst_en(dst_en),
    .xfer_inhibit(xfer_inhibit), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .uip(uip), .upd_done(upd_done), .alarm_hit(alarm_hit)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] benc(int v, bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] bhour(int h, bit f24, bit bin);
    int hh;
    logic [7:0] b;
    if (f24) return benc(h, bin);
    hh = h % 12;
    if (hh == 0) hh = 12;
    b = benc(hh, bin);
    return {(h >= 12), b[6:0]};
  endfunction

  function automatic int mdays(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    bit roll = 0;
    es++;
    if (es == 60) begin
      es = 0; em++;
      if (em == 60) begin
        em = 0; eh++;
        if (eh == 24) begin eh = 0; roll = 1; end
      end
    end
    if (roll) begin
      efell = 0;
      ew = (ew == 7) ? 1 : ew + 1;
      ed++;
      if (ed > mdays(emo, ey)) begin
        ed = 1; emo++;
        if (emo > 12) begin emo = 1; ey = (ey + 1) % 100; end
      end
    end
    if (dst_en && es == 0 && em == 0 && eh == 2 && ew == 1) begin
      if (emo == 4 && ed <= 7) eh = 3;
      else if (emo == 10 && ed >= 25 && !efell) begin eh = 1; efell = 1; end
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    wr_addr = 4'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done(output int n, output int up, output bit hit);
    n = 0; up = 0;
    do begin
      @(negedge clk);
      n++;
      if (uip) up++;
    end while (!upd_done);
    hit = alarm_hit;
  endtask

  task automatic load(int s, int m, int h, int w, int d, int mo, int y);
    es = s; em = m; eh = h; ew = w; ed = d; emo = mo; ey = y;
    wr(0, benc(s, fmt_binary));
    wr(1, benc(m, fmt_binary));
    wr(2, bhour(h, fmt_24h, fmt_binary));
    wr(3, benc(w, fmt_binary));
    wr(4, benc(d, fmt_binary));
    wr(5, benc(mo, fmt_binary));
    wr(6, benc(y, fmt_binary));
  endtask

  task automatic check_buf(string tag);
    logic [7:0] exp [7];
    exp[0] = benc(es, fmt_binary);
    exp[1] = benc(em, fmt_binary);
    exp[2] = bhour(eh, fmt_24h, fmt_binary);
    exp[3] = benc(ew, fmt_binary);
    exp[4] = benc(ed, fmt_binary);
    exp[5] = benc(emo, fmt_binary);
    exp[6] = benc(ey, fmt_binary);
    for (int i = 0; i < 7; i++) begin
      rd_addr = 4'(i);
      #1;
      chk($sformatf("%s field%0d", tag, i), rd_data, exp[i]);
      @(negedge clk);
    end
  endtask

  task automatic run_case(string tag, bit bin, bit f24, bit dst,
                          int s, int m, int h, int w, int d, int mo, int y);
    int n, up;
    bit hit;
    wait_done(n, up, hit);
    fmt_binary = bin; fmt_24h = f24; dst_en = dst;
    load(s, m, h, w, d, mo, y);
    wait_done(n, up, hit);
    model_step();
    check_buf(tag);
  endtask

  initial begin
    int n, up, cnt;
    bit hit;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 uip", uip, 0);
    chk("R1 upd_done", upd_done, 0);
    chk("R1 alarm_hit", alarm_hit, 0);
    es = 0; em = 0; eh = 0; ew = 1; ed = 1; emo = 1; ey = 0;
    check_buf("R1 reset");
    rd_addr = 4'd8; #1; chk("R1 alarm byte", rd_data, 8'h00);

    // R2 stopped divider: no update
    cnt = 0;
    repeat (3 * TPS) begin @(negedge clk); if (upd_done) cnt++; end
    chk("R2 stopped 000", cnt, 0);

    // R2 start latency, then full period; R3 uip lead
    osc_sel = 3'b010;
    wait_done(n, up, hit);
    chk("R2 first update latency", n, TPS / 2);
    wait_done(n, up, hit);
    chk("R2 update period", n, TPS);
    chk("R3 uip lead length", up, LEAD);
    es = 2; model_step(); es = 2; em = 0; eh = 0; ew = 1; ed = 1; emo = 1; ey = 0;
    check_buf("R2 counted two seconds");

    // R2 divider held by 11x pattern
    osc_sel = 3'b110;
    cnt = 0;
    repeat (3 * TPS) begin @(negedge clk); if (upd_done || uip) cnt++; end
    chk("R2 held 110", cnt, 0);
    osc_sel = 3'b011;
    wait_done(n, up, hit);
    chk("R2 restart latency 011", n, TPS / 2);

    // R5 carries, binary and BCD
    run_case("R5 bin sec carry", 1, 1, 0, 59, 14, 9, 3, 10, 6, 21);
    run_case("R5 bcd min carry", 0, 1, 0, 59, 59, 9, 3, 10, 6, 21);
    // R6 12-hour crossings
    run_case("R6 bin noon", 1, 0, 0, 59, 59, 11, 2, 5, 5, 30);
    run_case("R6 bcd 1pm", 0, 0, 0, 59, 59, 12, 2, 5, 5, 30);
    run_case("R6 bcd midnight", 0, 0, 0, 59, 59, 23, 2, 5, 5, 30);
    // R7 calendar boundaries
    run_case("R7 year wrap", 0, 1, 0, 59, 59, 23, 7, 31, 12, 99);
    run_case("R7 feb leap", 1, 1, 0, 59, 59, 23, 4, 28, 2, 24);
    run_case("R7 feb common", 0, 1, 0, 59, 59, 23, 4, 28, 2, 23);
    run_case("R7 feb29 end", 1, 1, 0, 59, 59, 23, 5, 29, 2, 24);
    run_case("R7 april 30", 0, 1, 0, 59, 59, 23, 6, 30, 4, 10);
    // R9 spring forward
    run_case("R9 spring jump", 1, 1, 1, 59, 59, 1, 1, 5, 4, 20);
    run_case("R9 second sunday none", 1, 1, 1, 59, 59, 1, 1, 12, 4, 20);
    // R10 fall back once
    run_case("R10 fall back", 0, 1, 1, 59, 59, 1, 1, 27, 10, 20);
    run_case("R10 no repeat", 0, 1, 1, 59, 59, 1, 1, 27, 10, 20);
    run_case("R10 rearm roll", 0, 1, 1, 59, 59, 23, 1, 27, 10, 20);
    dst_en = 1'b0;

    // R4 inhibit freezes buffer
    wait_done(n, up, hit);
    fmt_binary = 1; fmt_24h = 1;
    xfer_inhibit = 1'b1;
    load(30, 40, 10, 2, 3, 3, 33);
    wait_done(n, up, hit);
    chk("R4 uip held low", up, 0);
    check_buf("R4 frozen");
    xfer_inhibit = 1'b0;
    wait_done(n, up, hit);
    model_step(); model_step();
    check_buf("R4 resumed");

    // R8 alarm with don't-care bytes
    wait_done(n, up, hit);
    load(29, 20, 10, 2, 3, 3, 33);
    wr(7, 8'd30); wr(8, 8'hC0); wr(9, 8'hFF);
    wait_done(n, up, hit);
    chk("R8 per-minute alarm hit", hit, 1);
    wait_done(n, up, hit);
    chk("R8 no hit next second", hit, 0);
    wait_done(n, up, hit);
    load(29, 20, 10, 2, 3, 3, 33);
    wr(7, 8'd30); wr(8, 8'd20); wr(9, 8'd11);
    wait_done(n, up, hit);
    chk("R8 hour mismatch no hit", hit, 0);
    wait_done(n, up, hit);
    load(29, 20, 10, 2, 3, 3, 33);
    wr(9, 8'd10);
    wait_done(n, up, hit);
    chk("R8 full match hit", hit, 1);

    // R11 address map reads
    rd_addr = 4'd8; #1; chk("R11 alarm readback", rd_data, 8'd20);
    rd_addr = 4'd12; #1; chk("R11 unmapped read", rd_data, 8'h00);
    @(negedge clk);

    // R5 R6 R7 random mix
    for (int k = 0; k < 24; k++) begin
      int s, m, h, mo, y, d;
      s  = ($urandom % 2) ? 59 : $urandom % 60;
      m  = ($urandom % 2) ? 59 : $urandom % 60;
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      mo = 1 + $urandom % 12;
      y  = $urandom % 100;
      d  = ($urandom % 2) ? mdays(mo, y) : 1 + $urandom % mdays(mo, y);
      run_case($sformatf("R5 R6 R7 random %0d", k), 1'($urandom), 1'($urandom), 0,
               s, m, h, 1 + $urandom % 7, d, mo, y);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule